// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This unit resolves operand hazards for a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it compares the two source register numbers of the instruction in decode with the destinations of the instructions now in execute and memory. From that comparison it does three things. It registers a bypass select for each operand, and that select is used when the instruction reaches execute one cycle later. It raises a combinational stall that holds fetch and decode. It raises a bubble request that turns the execute-stage register into a no-op for that cycle.

A value produced by either of the two instructions ahead is taken from the pipeline rather than waited for. The exception is a load directly ahead of its consumer. Its data does not exist until the end of the memory stage, so the consumer waits one cycle and then takes the value from writeback. A producer three instructions ahead needs no path, because the register file writes early in the cycle and reads late. Ordering hazards between writes, and between a write and an older read, cannot arise, because operands are read in decode and every write happens in order in the last stage. The unit therefore does not examine them.

Top module: `fwdInterlockUnit`

## Requirements
- R1: If the instruction in execute writes a non-zero register that the decode instruction reads, and no stall is raised, the matching select is 2'b01 (memory-stage result) in the following cycle, and no stall is raised for an ALU producer.
- R2: If the instruction in memory writes a non-zero register that the decode instruction reads, and the execute instruction does not write it, the matching select is 2'b10 (writeback-stage result) in the following cycle. This also applies when the memory-stage producer is a load.
- R3: If the execute instruction is a valid load that writes a non-zero register read by either decode source, stallFront and bubbleEx are both 1 in that same cycle, and only in such cycles. When the consumer is re-examined one cycle later, the stall has cleared.
- R4: A select is 2'b00 (register file) when neither execute nor memory holds a matching producer, including a producer three instructions ahead.
- R5: If both the execute and memory instructions write the same register that a decode source reads, the select is 2'b01.
- R6: A producer whose destination is register 0, or whose write enable is 0, never causes a bypass or a stall.
- R7: A producer whose valid bit is 0 never causes a bypass or a stall, even when its destination field matches.
- R8: Both selects are 2'b00 while reset is asserted, and in the cycle after a stall, because the execute stage then holds a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decRs1 | input | REG_W | First source register of the decode instruction |
| decRs2 | input | REG_W | Second source register of the decode instruction |
| exRd | input | REG_W | Destination of the execute instruction |
| exWe | input | 1 | Execute instruction writes a register |
| exLoad | input | 1 | Execute instruction is a load |
| exValid | input | 1 | Execute stage holds a real instruction |
| memRd | input | REG_W | Destination of the memory-stage instruction |
| memWe | input | 1 | Memory-stage instruction writes a register |
| memValid | input | 1 | Memory stage holds a real instruction |
| stallFront | output | 1 | Hold the fetch and decode registers |
| bubbleEx | output | 1 | Load a no-op into the execute register |
| fwdSelA | output | 2 | Registered source select for execute operand A |
| fwdSelB | output | 2 | Registered source select for execute operand B |

## Verification
The assertions check the following on every cycle. Each select follows the producer comparison made one cycle earlier: the memory path wins over the writeback path, and nothing is selected when no producer matches. A stall is only ever raised for a valid load writing a non-zero register that decode reads, and selects are cleared behind every stall. Only the bench's behavioural pipeline can show that the right data actually arrives. It runs directed chains (load-use, distance one, two and three, register 0, non-writing producers, a double match, and a bubble carrying a stale destination), then random dependent code. It compares every retired result against a sequential register model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwdSel_e;

  // Match strobes handed from the compare datapath to the select control
  typedef struct packed {
    logic [NUM_SRC-1:0] exHit;
    logic [NUM_SRC-1:0] memHit;
    logic               exLoad;
  } hazStrobes_t;
endpackage

// File: rtl/fwdMatchPath.sv
module fwdMatchPath
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] decRs1,
  input  logic [REG_W-1:0] decRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exLoad,
  input  logic             exValid,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memValid,
  output hazStrobes_t      strobes
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] srcReg [NUM_SRC];
  logic [NUM_SRC-1:0] exHitV;
  logic [NUM_SRC-1:0] memHitV;
  logic exWrites;
  logic memWrites;

  assign srcReg[0] = decRs1;
  assign srcReg[1] = decRs2;

  // Only a real instruction writing a non-zero register can be a producer
  assign exWrites  = exValid  && exWe  && (exRd  != ZERO_REG);
  assign memWrites = memValid && memWe && (memRd != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign exHitV[i]  = exWrites  && (exRd  == srcReg[i]);
    assign memHitV[i] = memWrites && (memRd == srcReg[i]);
  end

  assign strobes = '{exHit: exHitV, memHit: memHitV, exLoad: exLoad};
endmodule

// File: rtl/fwdSelectCtrl.sv
module fwdSelectCtrl
  import fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hazStrobes_t strobes,
  output logic        stallFront,
  output logic        bubbleEx,
  output logic [1:0]  selA,
  output logic [1:0]  selB
);
  logic    loadUse;
  fwdSel_e selNext [NUM_SRC];
  fwdSel_e selQ    [NUM_SRC];

  // A load in execute cannot feed decode's consumer next cycle
  assign loadUse    = strobes.exLoad && (|strobes.exHit);
  assign stallFront = loadUse;
  assign bubbleEx   = loadUse;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    always_comb begin
      if (loadUse)                selNext[i] = FWD_RF;   // bubble follows
      else if (strobes.exHit[i])  selNext[i] = FWD_MEM;  // younger wins
      else if (strobes.memHit[i]) selNext[i] = FWD_WB;
      else                        selNext[i] = FWD_RF;
    end

    always_ff @(posedge clk) begin
      if (!rstN) selQ[i] <= FWD_RF;
      else       selQ[i] <= selNext[i];
    end
  end

  assign selA = selQ[0];
  assign selB = selQ[1];
endmodule

// File: rtl/fwdInterlockUnit.sv
module fwdInterlockUnit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] decRs1,
  input  logic [REG_W-1:0] decRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exLoad,
  input  logic             exValid,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memValid,
  output logic             stallFront,
  output logic             bubbleEx,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB
);
  hazStrobes_t strobes;

  fwdMatchPath #(.REG_W(REG_W)) u_match (
    .decRs1   (decRs1),
    .decRs2   (decRs2),
    .exRd     (exRd),
    .exWe     (exWe),
    .exLoad   (exLoad),
    .exValid  (exValid),
    .memRd    (memRd),
    .memWe    (memWe),
    .memValid (memValid),
    .strobes  (strobes)
  );

  fwdSelectCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .stallFront (stallFront),
    .bubbleEx   (bubbleEx),
    .selA       (fwdSelA),
    .selB       (fwdSelB)
  );
endmodule

// File: rtl/fwdInterlockChecker.sv
module fwdInterlockChecker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] decRs1,
  input logic [REG_W-1:0] decRs2,
  input logic [REG_W-1:0] exRd,
  input logic             exWe,
  input logic             exLoad,
  input logic             exValid,
  input logic [REG_W-1:0] memRd,
  input logic             memWe,
  input logic             memValid,
  input logic             stallFront,
  input logic             bubbleEx,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exHitA, exHitB, memHitA, memHitB;
  assign exHitA  = exValid  && exWe  && (exRd  != ZERO_REG) && (exRd  == decRs1);
  assign exHitB  = exValid  && exWe  && (exRd  != ZERO_REG) && (exRd  == decRs2);
  assign memHitA = memValid && memWe && (memRd != ZERO_REG) && (memRd == decRs1);
  assign memHitB = memValid && memWe && (memRd != ZERO_REG) && (memRd == decRs2);

  a_r1_mem_path: assert property (@(posedge clk) disable iff (!rstN)
    (!stallFront && exHitA) |=> (fwdSelA == 2'b01));

  a_r2_wb_path: assert property (@(posedge clk) disable iff (!rstN)
    (!stallFront && !exHitA && memHitA) |=> (fwdSelA == 2'b10));

  a_r3_stall_cause: assert property (@(posedge clk) disable iff (!rstN)
    stallFront |-> (exValid && exLoad && exWe && (exRd != ZERO_REG) &&
                    ((exRd == decRs1) || (exRd == decRs2))));

  a_r3_bubble_cause: assert property (@(posedge clk) disable iff (!rstN)
    bubbleEx |-> (exValid && exLoad));

  a_r4_regfile_path: assert property (@(posedge clk) disable iff (!rstN)
    (!exHitB && !memHitB) |=> (fwdSelB == 2'b00));

  a_r5_younger_first: assert property (@(posedge clk) disable iff (!rstN)
    (!stallFront && exHitB && memHitB) |=> (fwdSelB == 2'b01));

  a_r7_idle_stages: assert property (@(posedge clk) disable iff (!rstN)
    (!exValid && !memValid) |=> (fwdSelA == 2'b00 && fwdSelB == 2'b00));

  a_r8_clear_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    stallFront |=> (fwdSelA == 2'b00 && fwdSelB == 2'b00));
endmodule

bind fwdInterlockUnit fwdInterlockChecker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/fwdInterlockUnit_bench.sv
module fwdInterlockUnit_bench;
  localparam int REG_W   = 5;
  localparam int NRAND   = 3000;
  localparam int NSTEP   = 3400;
  localparam int WDOG_CY = 150000;

  typedef struct {
    bit          valid;
    bit          isLoad;
    bit          we;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
  } instr_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic stallFront, bubbleEx;
  logic [1:0] fwdSelA, fwdSelB;

  instr_t dI, eI, mI, wI;
  logic [31:0] eOpA, eOpB, mRes, wRes;
  logic [31:0] rf [32];
  logic [31:0] refRf [32];
  logic [1:0] prevSelA, prevSelB;
  instr_t dirQ [$];
  int nRandLeft;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  fwdInterlockUnit #(.REG_W(REG_W)) u_fwdInterlockUnit (
    .clk(clk), .rstN(rstN),
    .decRs1(dI.rs1), .decRs2(dI.rs2),
    .exRd(eI.rd), .exWe(eI.we), .exLoad(eI.isLoad), .exValid(eI.valid),
    .memRd(mI.rd), .memWe(mI.we), .memValid(mI.valid),
    .stallFront(stallFront), .bubbleEx(bubbleEx),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] aluOp(logic [31:0] a, logic [31:0] b, logic [31:0] k);
    return (a ^ {b[30:0], b[31]}) + k;
  endfunction

  function automatic logic [31:0] memData(logic [31:0] addr);
    return (addr * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction

  function automatic instr_t mk(bit ld, bit we, int rd, int rs1, int rs2);
    instr_t x;
    x.valid = 1'b1; x.isLoad = ld; x.we = we;
    x.rd = 5'(rd); x.rs1 = 5'(rs1); x.rs2 = 5'(rs2);
    x.imm = $urandom();
    return x;
  endfunction

  function automatic instr_t blank();
    instr_t x;
    x.valid = 1'b0; x.isLoad = 1'b0; x.we = 1'b0;
    x.rd = '0; x.rs1 = '0; x.rs2 = '0; x.imm = '0;
    return x;
  endfunction

  function automatic bit prodHit(instr_t p, logic [4:0] r);
    return p.valid && p.we && (p.rd != 0) && (p.rd == r);
  endfunction

  function automatic bit expStall();
    return eI.valid && eI.isLoad && (prodHit(eI, dI.rs1) || prodHit(eI, dI.rs2));
  endfunction

  function automatic logic [1:0] expSel(logic [4:0] r, bit st);
    if (st) return 2'b00;
    if (prodHit(eI, r)) return 2'b01;
    if (prodHit(mI, r)) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string selTag(logic [4:0] r, bit st);
    if (st) return "R8";
    if (r == 0) return "R6";
    if (prodHit(eI, r) && prodHit(mI, r)) return "R5";
    if (prodHit(eI, r)) return "R1";
    if (prodHit(mI, r)) return "R2";
    if ((eI.rd == r && !eI.valid) || (mI.rd == r && !mI.valid)) return "R7";
    if (eI.rd == r || mI.rd == r) return "R6";
    return "R4";
  endfunction

  function automatic logic [31:0] rdRf(logic [4:0] r);
    if (r == 0) return 32'h0;
    if (wI.valid && wI.we && wI.rd == r) return wRes;  // write before read
    return rf[r];
  endfunction

  function automatic instr_t nextInstr();
    if (dirQ.size() > 0) return dirQ.pop_front();
    if (nRandLeft > 0) begin
      nRandLeft--;
      return mk(($urandom_range(3) == 0), ($urandom_range(7) != 0),
                $urandom_range(7), $urandom_range(7), $urandom_range(7));
    end
    return blank();
  endfunction

  task automatic step();
    bit st, bu, es;
    logic [1:0] sA, sB, eA, eB;
    logic [31:0] opA, opB, exp, newMRes, newWRes;
    instr_t newE;
    st = stallFront; bu = bubbleEx; sA = fwdSelA; sB = fwdSelB;
    es = expStall();
    eA = expSel(dI.rs1, es); eB = expSel(dI.rs2, es);
    chk(st == es, "R3", "stallFront", 32'(st), 32'(es));
    chk(bu == es, "R3", "bubbleEx", 32'(bu), 32'(es));
    chk(sA == eA, selTag(dI.rs1, es), "fwdSelA", 32'(sA), 32'(eA));
    chk(sB == eB, selTag(dI.rs2, es), "fwdSelB", 32'(sB), 32'(eB));

    // Retiring instruction against the sequential register model
    if (wI.valid) begin
      exp = wI.isLoad ? memData(refRf[wI.rs1] + wI.imm)
                      : aluOp(refRf[wI.rs1], refRf[wI.rs2], wI.imm);
      chk(wRes == exp, "R1 R2 R3 R4 R5 R6 R7", "retired result", wRes, exp);
      if (wI.we && wI.rd != 0) refRf[wI.rd] = exp;
    end

    // Execute with the select that was registered for this instruction
    opA = (prevSelA == 2'b01) ? mRes : (prevSelA == 2'b10) ? wRes : eOpA;
    opB = (prevSelB == 2'b01) ? mRes : (prevSelB == 2'b10) ? wRes : eOpB;
    newMRes = eI.isLoad ? (opA + eI.imm) : aluOp(opA, opB, eI.imm);
    newWRes = mI.isLoad ? memData(mRes) : mRes;

    if (st) begin
      newE = dI; newE.valid = 1'b0;  // bubble keeps a stale destination
    end else begin
      newE = dI;
      eOpA = rdRf(dI.rs1);
      eOpB = rdRf(dI.rs2);
    end
    if (wI.valid && wI.we && wI.rd != 0) rf[wI.rd] = wRes;
    wI = mI; wRes = newWRes;
    mI = eI; mRes = newMRes;
    eI = newE;
    if (!st) dI = nextInstr();
    prevSelA = sA; prevSelB = sB;
  endtask

  initial begin
    void'($urandom(32'd20240303));
    for (int i = 0; i < 32; i++) begin
      rf[i] = (i == 0) ? 32'h0 : (32'(i) * 32'h01010101 + 32'd7);
      refRf[i] = rf[i];
    end
    nRandLeft = NRAND;
    // Directed chains, fillers use registers 20..22 to avoid stray matches
    dirQ.push_back(mk(0, 1, 1, 2, 3));
    dirQ.push_back(mk(0, 1, 4, 1, 3));   // R1 distance one
    dirQ.push_back(mk(0, 1, 5, 6, 1));   // R2 distance two on operand B
    dirQ.push_back(mk(0, 1, 7, 1, 1));   // R4 distance three
    dirQ.push_back(mk(1, 1, 8, 2, 20));
    dirQ.push_back(mk(0, 1, 8, 8, 3));   // R3 load-use, R7 stale bubble rd
    dirQ.push_back(mk(1, 1, 10, 2, 20));
    dirQ.push_back(mk(0, 1, 20, 21, 22));
    dirQ.push_back(mk(0, 1, 11, 10, 10)); // R2 load two ahead, no stall
    dirQ.push_back(mk(0, 1, 0, 2, 3));
    dirQ.push_back(mk(0, 1, 12, 0, 0));   // R6 register 0 producer
    dirQ.push_back(mk(1, 1, 0, 2, 20));
    dirQ.push_back(mk(0, 1, 13, 0, 3));   // R6 load to register 0
    dirQ.push_back(mk(0, 0, 14, 2, 3));
    dirQ.push_back(mk(0, 1, 15, 14, 3));  // R6 non-writing producer
    dirQ.push_back(mk(0, 1, 16, 21, 22));
    dirQ.push_back(mk(0, 1, 16, 2, 3));
    dirQ.push_back(mk(0, 1, 17, 16, 16)); // R5 double match
    dirQ.push_back(mk(1, 1, 18, 2, 20));
    dirQ.push_back(mk(0, 1, 19, 20, 18)); // R3 load-use on operand B
    dI = blank(); eI = blank(); mI = blank(); wI = blank();
    eOpA = '0; eOpB = '0; mRes = '0; wRes = '0;
    prevSelA = '0; prevSelB = '0;

    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(fwdSelA == 2'b00, "R8", "fwdSelA in reset", 32'(fwdSelA), 32'h0);
    chk(fwdSelB == 2'b00, "R8", "fwdSelB in reset", 32'(fwdSelB), 32'h0);
    chk(stallFront == 1'b0, "R3", "stall in reset", 32'(stallFront), 32'h0);
    rstN = 1'b1;
    for (int n = 0; n < NSTEP; n++) begin
      @(negedge clk);
      step();
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WDOG_CY) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule